// File: doc/BRIEF.md
# Multi-Cycle Processor Datapath

This block is the datapath of a 32-bit processor that executes each instruction over several clock cycles. It holds thirty-two general registers, the program counter, the instruction register and the memory address and data registers. It also contains the ALU, a separate adder that steps the program counter, and the logic that decodes instruction fields, builds branch and jump targets and tests branch conditions. Each cycle a control word applied at its inputs selects which register transfers happen at the next rising clock edge. An external sequencer supplies that control word. The block itself holds no state machine.

Memory is reached through an address/data port. The address always shows the memory address register and the write data always shows the memory data register. Read and write strobes pass straight from the control word to the port, and read data is taken into the data register when the control word asks for it. Instructions are fetched by loading read data into the data register and then moving it to the instruction register.

Top module: `mc_datapath`

## Requirements
- R1: While `rst_n` is low, PC, IR, MAR, MDR and every general register read as zero, so `pc`, `ir`, `mem_addr` and `mem_wdata` are all zero.
- R2: When `ctl_pc_inc` is 1 and no redirect happens, PC becomes PC+4 at the edge. This uses its own adder, so an ALU write-back can take place in the same cycle.
- R3: Register fields are decoded from IR as follows: destination in bits 25..21, first source in 20..16, second source in 15..11. When `ctl_mdr_sel`=2, MDR takes the register named in bits 25..21, which is the slot a store uses for its data register.
- R4: With `ctl_b_imm`=0, the ALU takes the second source register. `ctl_alu_op` selects the operation: 0 add, 1 subtract, 2 multiply (low 32 bits), 3 unsigned divide, 4 AND, 5 OR, 6 shift left, 7 shift right. When `ctl_rf_we`=1 and `ctl_rf_src` is 0 or 3, the result is written to the destination register.
- R5: With `ctl_b_imm`=1, the second operand is IR bits 15..0. It is zero-extended for operations 4 and 5 and sign-extended for all others. Shifts are logical and use the low 5 bits of the operand as the shift amount.
- R6: Divide by zero returns all ones in the same cycle.
- R7: `br_taken` tests the first source register as a signed value, with `ctl_br_cond` 0 for less than zero, 1 for greater than zero, 2 for equal to zero and 3 for not equal to zero. With `ctl_pc_sel`=1 and the test true, PC becomes PC + (sign-extended IR[15:0] × 4). When the test is false, PC does not take the target.
- R8: With `ctl_pc_sel`=2, PC becomes PC + (sign-extended IR[25:0] × 4). With `ctl_pc_sel`=3, PC becomes the first source register plus sign-extended IR[15:0].
- R9: When `ctl_rf_we`=1 and `ctl_rf_src`=2, the current PC is written into R31.
- R10: `ctl_mar_sel` 1 loads MAR from PC and 2 loads it from the ALU result. `ctl_mdr_sel` 1 loads MDR from `mem_rdata`. `ctl_ir_ld` loads IR from MDR. `mem_addr` shows MAR, `mem_wdata` shows MDR, and `mem_rd`/`mem_wr` follow `ctl_mem_rd`/`ctl_mem_wr`.
- R11: R0 is an ordinary register: it can be written and read back like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_pc_inc | input | 1 | Step PC by 4 |
| ctl_pc_sel | input | 2 | PC redirect: 0 none, 1 branch, 2 relative jump, 3 register jump |
| ctl_br_cond | input | 2 | Branch test on first source register |
| ctl_mar_sel | input | 2 | MAR source: 0 hold, 1 PC, 2 ALU |
| ctl_mdr_sel | input | 2 | MDR source: 0 hold, 1 read data, 2 store register |
| ctl_ir_ld | input | 1 | Load IR from MDR |
| ctl_rf_we | input | 1 | Register file write enable |
| ctl_rf_src | input | 2 | Write source: 0/3 ALU to destination, 1 MDR to destination, 2 PC to R31 |
| ctl_alu_op | input | 3 | ALU operation code |
| ctl_b_imm | input | 1 | Second ALU operand from immediate |
| ctl_mem_rd | input | 1 | Memory read strobe request |
| ctl_mem_wr | input | 1 | Memory write strobe request |
| mem_rdata | input | 32 | Memory read data |
| mem_addr | output | 32 | Memory address (MAR) |
| mem_wdata | output | 32 | Memory write data (MDR) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| pc | output | 32 | Program counter |
| ir | output | 32 | Instruction register |
| br_taken | output | 1 | Branch test result |

## Verification
The bound checker checks a set of rules on every cycle:
- the PC step of four;
- a false branch test leaving the PC unchanged;
- the equal-to-zero test agreeing with the register contents;
- the all-ones result of a zero divide;
- MAR capturing the PC;
- IR capturing MDR.

Only the bench scenarios can show the arithmetic results written back and read out again through the store path. The same holds for the immediate extension rules, the branch and jump target arithmetic, the link write into R31, and R0 behaving as a normal register.

// File: rtl/mcdp_pkg.sv
package mcdp_pkg;

   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_SUB = 3'd1,
      OP_MUL = 3'd2,
      OP_DIV = 3'd3,
      OP_AND = 3'd4,
      OP_OR  = 3'd5,
      OP_SHL = 3'd6,
      OP_SHR = 3'd7
   } alu_op_e;

   typedef enum logic [1:0] {
      PCS_NONE = 2'd0,
      PCS_BR   = 2'd1,
      PCS_JREL = 2'd2,
      PCS_JREG = 2'd3
   } pc_sel_e;

   typedef enum logic [1:0] {
      COND_LT = 2'd0,
      COND_GT = 2'd1,
      COND_EQ = 2'd2,
      COND_NE = 2'd3
   } br_cond_e;

   typedef enum logic [1:0] {
      MAR_HOLD = 2'd0,
      MAR_PC   = 2'd1,
      MAR_ALU  = 2'd2
   } mar_sel_e;

   typedef enum logic [1:0] {
      MDR_HOLD = 2'd0,
      MDR_MEM  = 2'd1,
      MDR_REG  = 2'd2
   } mdr_sel_e;

   typedef enum logic [1:0] {
      WB_ALU  = 2'd0,
      WB_MDR  = 2'd1,
      WB_LINK = 2'd2
   } wb_src_e;

   localparam int unsigned RIDX_W    = 5;
   localparam int unsigned IMM_W     = 16;
   localparam int unsigned JOFF_W    = 26;
   localparam int unsigned FLD_RD_LO = 21;
   localparam int unsigned FLD_RS_LO = 16;
   localparam int unsigned FLD_RT_LO = 11;

endpackage

// File: rtl/mcdp_fields.sv
module mcdp_fields
   import mcdp_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  logic [XLEN-1:0]   ir,
   input  logic [XLEN-1:0]   pc,
   input  logic [XLEN-1:0]   rs1_data,
   input  logic [1:0]        br_cond,
   input  logic [2:0]        alu_op,
   output logic [RIDX_W-1:0] rd_a,
   output logic [RIDX_W-1:0] rs1_a,
   output logic [RIDX_W-1:0] rs2_a,
   output logic [XLEN-1:0]   imm_ext,
   output logic [XLEN-1:0]   br_tgt,
   output logic [XLEN-1:0]   jrel_tgt,
   output logic [XLEN-1:0]   jreg_tgt,
   output logic              cond_true
);

   localparam int unsigned BSEXT = XLEN - IMM_W - 2;
   localparam int unsigned JSEXT = XLEN - JOFF_W - 2;

   logic [IMM_W-1:0]  imm;
   logic [JOFF_W-1:0] joff;
   logic [XLEN-1:0]   imm_sx;
   logic [XLEN-1:0]   imm_zx;
   logic              unused_opc;
   logic              is_neg;
   logic              is_zero;

   assign rd_a  = ir[FLD_RD_LO +: RIDX_W];
   assign rs1_a = ir[FLD_RS_LO +: RIDX_W];
   assign rs2_a = ir[FLD_RT_LO +: RIDX_W];
   assign imm   = ir[IMM_W-1:0];
   assign joff  = ir[JOFF_W-1:0];
   assign unused_opc = ^ir[XLEN-1:JOFF_W];

   assign imm_sx = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
   assign imm_zx = {{(XLEN-IMM_W){1'b0}}, imm};

   always_comb begin
      if (alu_op == OP_AND || alu_op == OP_OR) imm_ext = imm_zx;
      else                                      imm_ext = imm_sx;
   end

   assign br_tgt   = pc + {{BSEXT{imm[IMM_W-1]}}, imm, 2'b00};
   assign jrel_tgt = pc + {{JSEXT{joff[JOFF_W-1]}}, joff, 2'b00};
   assign jreg_tgt = rs1_data + imm_sx;

   assign is_neg  = rs1_data[XLEN-1];
   assign is_zero = (rs1_data == '0);

   always_comb begin
      unique case (br_cond)
         COND_LT: cond_true = is_neg;
         COND_GT: cond_true = !is_neg && !is_zero;
         COND_EQ: cond_true = is_zero;
         default: cond_true = !is_zero;
      endcase
   end

endmodule

// File: rtl/mcdp_regfile.sv
module mcdp_regfile
   import mcdp_pkg::*;
#(
   parameter int unsigned XLEN = 32,
   parameter int unsigned NREG = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [RIDX_W-1:0] wa,
   input  logic [XLEN-1:0]   wd,
   input  logic [RIDX_W-1:0] ra1,
   input  logic [RIDX_W-1:0] ra2,
   input  logic [RIDX_W-1:0] ra3,
   output logic [XLEN-1:0]   rd1,
   output logic [XLEN-1:0]   rd2,
   output logic [XLEN-1:0]   rd3
);

   logic [XLEN-1:0] regs [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)                        regs[g] <= '0;
         else if (we && wa == RIDX_W'(g))   regs[g] <= wd;
      end
   end

   assign rd1 = regs[ra1];
   assign rd2 = regs[ra2];
   assign rd3 = regs[ra3];

endmodule

// File: rtl/mcdp_alu.sv
module mcdp_alu
   import mcdp_pkg::*;
#(
   parameter int unsigned XLEN       = 32,
   parameter bit          HAS_MULDIV = 1'b1
) (
   input  logic [2:0]      op,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic [XLEN-1:0] y
);

   localparam int unsigned SHW = $clog2(XLEN);

   logic [XLEN-1:0] mul_y;
   logic [XLEN-1:0] div_y;
   logic [SHW-1:0]  shamt;

   assign shamt = b[SHW-1:0];

   if (HAS_MULDIV) begin : g_muldiv
      assign mul_y = a * b;
      assign div_y = (b == '0) ? '1 : (a / b);
   end else begin : g_nomuldiv
      assign mul_y = '0;
      assign div_y = '1;
   end

   always_comb begin
      unique case (op)
         OP_ADD:  y = a + b;
         OP_SUB:  y = a - b;
         OP_MUL:  y = mul_y;
         OP_DIV:  y = div_y;
         OP_AND:  y = a & b;
         OP_OR:   y = a | b;
         OP_SHL:  y = a << shamt;
         default: y = a >> shamt;
      endcase
   end

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
   import mcdp_pkg::*;
#(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned NREG       = 32,
   parameter int unsigned PC_STEP    = 4,
   parameter logic [31:0] PC_RESET   = 32'h0,
   parameter bit          HAS_MULDIV = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ctl_pc_inc,
   input  logic [1:0]      ctl_pc_sel,
   input  logic [1:0]      ctl_br_cond,
   input  logic [1:0]      ctl_mar_sel,
   input  logic [1:0]      ctl_mdr_sel,
   input  logic            ctl_ir_ld,
   input  logic            ctl_rf_we,
   input  logic [1:0]      ctl_rf_src,
   input  logic [2:0]      ctl_alu_op,
   input  logic            ctl_b_imm,
   input  logic            ctl_mem_rd,
   input  logic            ctl_mem_wr,
   input  logic [XLEN-1:0] mem_rdata,
   output logic [XLEN-1:0] mem_addr,
   output logic [XLEN-1:0] mem_wdata,
   output logic            mem_rd,
   output logic            mem_wr,
   output logic [XLEN-1:0] pc,
   output logic [XLEN-1:0] ir,
   output logic            br_taken
);

   localparam int unsigned LINK_REG = NREG - 1;

   if (XLEN < 32) begin : g_chk_xlen
      $error("mc_datapath: XLEN must be at least 32");
   end
   if (NREG != (1 << RIDX_W)) begin : g_chk_nreg
      $error("mc_datapath: NREG must match the 5-bit register fields");
   end
   if (PC_STEP == 0) begin : g_chk_step
      $error("mc_datapath: PC_STEP must be nonzero");
   end

   logic [XLEN-1:0]   mar_q;
   logic [XLEN-1:0]   mdr_q;
   logic [XLEN-1:0]   pc_plus;
   logic [RIDX_W-1:0] rd_a, rs1_a, rs2_a, wr_a;
   logic [XLEN-1:0]   rs1_d, rs2_d, st_d;
   logic [XLEN-1:0]   imm_ext;
   logic [XLEN-1:0]   br_tgt, jrel_tgt, jreg_tgt;
   logic [XLEN-1:0]   alu_b, alu_y, wr_d;

   mcdp_fields #(.XLEN(XLEN)) u_fields (
      .ir        (ir),
      .pc        (pc),
      .rs1_data  (rs1_d),
      .br_cond   (ctl_br_cond),
      .alu_op    (ctl_alu_op),
      .rd_a      (rd_a),
      .rs1_a     (rs1_a),
      .rs2_a     (rs2_a),
      .imm_ext   (imm_ext),
      .br_tgt    (br_tgt),
      .jrel_tgt  (jrel_tgt),
      .jreg_tgt  (jreg_tgt),
      .cond_true (br_taken)
   );

   always_comb begin
      unique case (ctl_rf_src)
         WB_MDR:  begin wr_a = rd_a;                  wr_d = mdr_q; end
         WB_LINK: begin wr_a = RIDX_W'(LINK_REG);     wr_d = pc;    end
         default: begin wr_a = rd_a;                  wr_d = alu_y; end
      endcase
   end

   mcdp_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ctl_rf_we),
      .wa    (wr_a),
      .wd    (wr_d),
      .ra1   (rs1_a),
      .ra2   (rs2_a),
      .ra3   (rd_a),
      .rd1   (rs1_d),
      .rd2   (rs2_d),
      .rd3   (st_d)
   );

   assign alu_b = ctl_b_imm ? imm_ext : rs2_d;

   mcdp_alu #(.XLEN(XLEN), .HAS_MULDIV(HAS_MULDIV)) u_alu (
      .op (ctl_alu_op),
      .a  (rs1_d),
      .b  (alu_b),
      .y  (alu_y)
   );

   assign pc_plus = pc + XLEN'(PC_STEP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc <= XLEN'(PC_RESET);
      end else if (ctl_pc_sel == PCS_BR && br_taken) begin
         pc <= br_tgt;
      end else if (ctl_pc_sel == PCS_JREL) begin
         pc <= jrel_tgt;
      end else if (ctl_pc_sel == PCS_JREG) begin
         pc <= jreg_tgt;
      end else if (ctl_pc_inc) begin
         pc <= pc_plus;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mar_q <= '0;
         mdr_q <= '0;
         ir    <= '0;
      end else begin
         unique case (ctl_mar_sel)
            MAR_PC:  mar_q <= pc;
            MAR_ALU: mar_q <= alu_y;
            default: mar_q <= mar_q;
         endcase
         unique case (ctl_mdr_sel)
            MDR_MEM: mdr_q <= mem_rdata;
            MDR_REG: mdr_q <= st_d;
            default: mdr_q <= mdr_q;
         endcase
         if (ctl_ir_ld) ir <= mdr_q;
      end
   end

   assign mem_addr  = mar_q;
   assign mem_wdata = mdr_q;
   assign mem_rd    = ctl_mem_rd;
   assign mem_wr    = ctl_mem_wr;

endmodule

// File: rtl/mcdp_checker.sv
module mcdp_checker #(
   parameter int unsigned XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            pc_inc,
   input logic [1:0]      pc_sel,
   input logic [1:0]      br_cond,
   input logic [1:0]      mar_sel,
   input logic            ir_ld,
   input logic [2:0]      alu_op,
   input logic [XLEN-1:0] pc,
   input logic [XLEN-1:0] ir,
   input logic [XLEN-1:0] mem_addr,
   input logic [XLEN-1:0] mem_wdata,
   input logic            br_taken,
   input logic [XLEN-1:0] rs1_data,
   input logic [XLEN-1:0] alu_b,
   input logic [XLEN-1:0] alu_y
);

   a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_inc && pc_sel == 2'd0) |=> (pc == $past(pc) + XLEN'(4)));

   a_r7_branch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_sel == 2'd1 && !br_taken && !pc_inc) |=> $stable(pc));

   a_r7_eq_test: assert property (@(posedge clk) disable iff (!rst_n)
      (br_cond == 2'd2) |-> (br_taken == (rs1_data == '0)));

   a_r6_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_op == 3'd3 && alu_b == '0) |-> (alu_y == '1));

   a_r10_mar_pc: assert property (@(posedge clk) disable iff (!rst_n)
      (mar_sel == 2'd1) |=> (mem_addr == $past(pc)));

   a_r10_ir_load: assert property (@(posedge clk) disable iff (!rst_n)
      ir_ld |=> (ir == $past(mem_wdata)));

endmodule

bind mc_datapath mcdp_checker #(.XLEN(XLEN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pc_inc    (ctl_pc_inc),
   .pc_sel    (ctl_pc_sel),
   .br_cond   (ctl_br_cond),
   .mar_sel   (ctl_mar_sel),
   .ir_ld     (ctl_ir_ld),
   .alu_op    (ctl_alu_op),
   .pc        (pc),
   .ir        (ir),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .br_taken  (br_taken),
   .rs1_data  (rs1_d),
   .alu_b     (alu_b),
   .alu_y     (alu_y)
);

// File: tb/mc_datapath_bench.sv
`timescale 1ns/1ps
module mc_datapath_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        c_pc_inc = 0, c_ir_ld = 0, c_rf_we = 0, c_b_imm = 0, c_mem_rd = 0, c_mem_wr = 0;
   logic [1:0]  c_pc_sel = 0, c_br_cond = 0, c_mar_sel = 0, c_mdr_sel = 0, c_rf_src = 0;
   logic [2:0]  c_alu_op = 0;
   logic [31:0] rdata = 0;
   logic [31:0] mem_addr, mem_wdata, pc, ir;
   logic        mem_rd, mem_wr, br_taken;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   mc_datapath u_mc_datapath (
      .clk(clk), .rst_n(rst_n),
      .ctl_pc_inc(c_pc_inc), .ctl_pc_sel(c_pc_sel), .ctl_br_cond(c_br_cond),
      .ctl_mar_sel(c_mar_sel), .ctl_mdr_sel(c_mdr_sel), .ctl_ir_ld(c_ir_ld),
      .ctl_rf_we(c_rf_we), .ctl_rf_src(c_rf_src), .ctl_alu_op(c_alu_op),
      .ctl_b_imm(c_b_imm), .ctl_mem_rd(c_mem_rd), .ctl_mem_wr(c_mem_wr),
      .mem_rdata(rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .pc(pc), .ir(ir), .br_taken(br_taken)
   );

   // ALU vectors: op, immediate flag, R1 value, R2 value or 16-bit immediate, expected R3
   localparam int NV = 13;
   localparam logic [2:0]  V_OP  [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd3, 3'd4, 3'd5,
                                          3'd0, 3'd1, 3'd4, 3'd5, 3'd6, 3'd7};
   localparam logic        V_IMM [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                                          1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
   localparam logic [31:0] V_A   [NV] = '{32'd5, 32'd3, 32'hFFFFFFFF, 32'd100, 32'd9,
                                          32'hF0F0F0F0, 32'hF0000000, 32'd10, 32'd0,
                                          32'h12345678, 32'd0, 32'h80000001, 32'h80000000};
   localparam logic [31:0] V_B   [NV] = '{32'd7, 32'd5, 32'd3, 32'd7, 32'd0,
                                          32'h0FF00FF0, 32'h00000001, 32'hFFFF, 32'h8000,
                                          32'hFFFF, 32'h8000, 32'd4, 32'd4};
   localparam logic [31:0] V_EXP [NV] = '{32'd12, 32'hFFFFFFFE, 32'hFFFFFFFD, 32'd14,
                                          32'hFFFFFFFF, 32'h00F000F0, 32'hF0000001, 32'd9,
                                          32'h00008000, 32'h00005678, 32'h00008000,
                                          32'h00000010, 32'h08000000};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      c_pc_inc = 0; c_pc_sel = 0; c_br_cond = 0; c_mar_sel = 0; c_mdr_sel = 0;
      c_ir_ld = 0; c_rf_we = 0; c_rf_src = 0; c_alu_op = 0; c_b_imm = 0;
      c_mem_rd = 0; c_mem_wr = 0;
   endtask

   task automatic clk1();
      @(posedge clk);
      @(negedge clk);
      idle();
   endtask

   task automatic load_ir(input logic [31:0] w);
      rdata = w; c_mdr_sel = 2'd1; clk1();
      c_ir_ld = 1; clk1();
   endtask

   task automatic set_reg(input logic [4:0] r, input logic [31:0] v);
      load_ir({6'd0, r, 21'd0});
      rdata = v; c_mdr_sel = 2'd1; clk1();
      c_rf_we = 1; c_rf_src = 2'd1; clk1();
   endtask

   task automatic read_reg(input logic [4:0] r, output logic [31:0] v);
      load_ir({6'd0, r, 21'd0});
      c_mdr_sel = 2'd2; clk1();
      v = mem_wdata;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [31:0] v;
      logic [31:0] p;
      idle();
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 pc", pc, 32'h0);
      chk("R1 ir", ir, 32'h0);
      chk("R1 mar", mem_addr, 32'h0);
      chk("R1 mdr", mem_wdata, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4 R5 R6: vector table
      for (int i = 0; i < NV; i++) begin
         set_reg(5'd1, V_A[i]);
         if (!V_IMM[i]) begin
            set_reg(5'd2, V_B[i]);
            load_ir({6'd0, 5'd3, 5'd1, 5'd2, 11'd0});
         end else begin
            load_ir({6'd0, 5'd3, 5'd1, V_B[i][15:0]});
         end
         c_rf_we = 1; c_rf_src = 2'd0; c_alu_op = V_OP[i]; c_b_imm = V_IMM[i]; clk1();
         read_reg(5'd3, v);
         chk($sformatf("R4/R5/R6 vec%0d", i), v, V_EXP[i]);
      end

      // R10: IR load from MDR
      load_ir(32'hDEAD_BEEF);
      chk("R10 ir load", ir, 32'hDEADBEEF);

      // R11: R0 writable
      set_reg(5'd0, 32'h0000ABCD);
      read_reg(5'd0, v);
      chk("R11 r0", v, 32'h0000ABCD);

      // R3: store slot 25..21 feeds MDR, not 15..11
      set_reg(5'd5, 32'h5555_0005);
      set_reg(5'd2, 32'h2222_0002);
      load_ir({6'd0, 5'd5, 5'd0, 5'd2, 11'd0});
      c_mdr_sel = 2'd2; clk1();
      chk("R3 store slot", mem_wdata, 32'h55550005);

      // R2: PC step together with ALU write
      set_reg(5'd1, 32'd20);
      set_reg(5'd2, 32'd22);
      load_ir({6'd0, 5'd3, 5'd1, 5'd2, 11'd0});
      p = pc;
      c_pc_inc = 1; c_rf_we = 1; c_alu_op = 3'd0; clk1();
      chk("R2 pc step", pc, p + 32'd4);
      read_reg(5'd3, v);
      chk("R2 parallel alu", v, 32'd42);

      // R10: MAR from ALU and from PC, strobes
      set_reg(5'd1, 32'h40);
      load_ir({6'd0, 5'd0, 5'd1, 16'h0008});
      c_mar_sel = 2'd2; c_b_imm = 1; c_alu_op = 3'd0; clk1();
      chk("R10 mar alu", mem_addr, 32'h48);
      c_pc_inc = 1; clk1();
      c_mar_sel = 2'd1; clk1();
      chk("R10 mar pc", mem_addr, pc);
      c_mem_wr = 1; c_mem_rd = 0; #1;
      chk("R10 mem_wr", {31'd0, mem_wr}, 32'd1);
      chk("R10 mem_rd", {31'd0, mem_rd}, 32'd0);
      idle();

      // R7: branch conditions and targets
      set_reg(5'd1, 32'hFFFFFFFB);
      load_ir({6'd0, 5'd0, 5'd1, 16'h0003});
      c_br_cond = 2'd0; #1;
      chk("R7 lt flag", {31'd0, br_taken}, 32'd1);
      p = pc;
      c_pc_sel = 2'd1; clk1();
      chk("R7 lt taken", pc, p + 32'd12);
      p = pc;
      c_br_cond = 2'd1; c_pc_sel = 2'd1; #1;
      chk("R7 gt flag", {31'd0, br_taken}, 32'd0);
      clk1();
      chk("R7 gt not taken", pc, p);
      set_reg(5'd1, 32'd0);
      load_ir({6'd0, 5'd0, 5'd1, 16'hFFFF});
      p = pc;
      c_br_cond = 2'd3; #1;
      chk("R7 ne flag", {31'd0, br_taken}, 32'd0);
      c_br_cond = 2'd2; c_pc_sel = 2'd1; clk1();
      chk("R7 eq taken back", pc, p - 32'd4);

      // R8: relative and register jumps
      load_ir({6'd0, 26'h3FFFFFE});
      p = pc;
      c_pc_sel = 2'd2; clk1();
      chk("R8 jump rel", pc, p - 32'd8);
      set_reg(5'd1, 32'h100);
      load_ir({6'd0, 5'd0, 5'd1, 16'h0010});
      c_pc_sel = 2'd3; clk1();
      chk("R8 jump reg", pc, 32'h110);

      // R9: link into R31
      c_pc_inc = 1; clk1();
      p = pc;
      c_rf_we = 1; c_rf_src = 2'd2; clk1();
      read_reg(5'd31, v);
      chk("R9 link", v, p);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule